// File: doc/BRIEF.md
# Two-Port Interleaving SRAM Arbiter

This block shares one word-wide synchronous SRAM between two requesters. The first is the processor's data port. The second is a system-bus master such as a DMA engine. Each port presents a single-word access: request, word address, write enable, byte enables and write data. Each port gets back a ready/grant flag and a read-data bus. The SRAM sits behind the arbiter, and its width and depth are parameters.

When only one port is asking, that port owns the SRAM in the same cycle and its access completes at the next clock edge, with no wait state. When both ask at once, ownership swaps after every word: the port that did not make the most recent transfer goes first. Under continuous contention, neither side ever waits more than one cycle. When neither port asks, the grant stays on the port that used the SRAM last. That port therefore sees its ready flag already high on its next access. A port whose ready flag is low must hold its request and its access fields steady until it is granted.

Top module: `sram_share_arb`

## Requirements
- R1: After synchronous reset, with no requests, the grant is parked on the processor port: `cpu_gnt`=1, `bus_gnt`=0, and both read-data buses are zero.
- R2: A port that requests while the other port does not is granted in the same cycle, with no wait state.
- R3: When both ports request in the same cycle, the grant goes to the port that did not own the previous cycle. A requesting port that is not granted is therefore granted in the next cycle, so the two ports alternate one word at a time.
- R4: In a cycle with no requests, the grant remains with the port that owned the previous cycle.
- R5: In every cycle after reset, exactly one of `cpu_gnt` and `bus_gnt` is high.
- R6: A granted write updates only the bytes whose enable bit is set. Enable bit i covers data bits 8i+7 down to 8i. All other bytes of the word keep their old value.
- R7: A granted read (request high, write enable low) returns the addressed word on that port's read-data bus in the cycle after the grant. In every other cycle, that port's read-data bus is zero.
- R8: Write enable, address and data on a port whose request is low have no effect on the SRAM, even while that port holds the parked grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor port access request |
| cpu_addr | input | ADDR_W | Processor port word address |
| cpu_we | input | 1 | Processor port write enable (1 = write) |
| cpu_be | input | DATA_W/8 | Processor port byte enables |
| cpu_wdata | input | DATA_W | Processor port write data |
| cpu_rdata | output | DATA_W | Processor port read data, valid the cycle after a granted read |
| cpu_gnt | output | 1 | Processor port owns the SRAM this cycle |
| bus_req | input | 1 | System-bus port access request |
| bus_addr | input | ADDR_W | System-bus port word address |
| bus_we | input | 1 | System-bus port write enable (1 = write) |
| bus_be | input | DATA_W/8 | System-bus port byte enables |
| bus_wdata | input | DATA_W | System-bus port write data |
| bus_rdata | output | DATA_W | System-bus port read data, valid the cycle after a granted read |
| bus_gnt | output | 1 | System-bus port owns the SRAM this cycle |

## Verification
A corrupted last-owner register shows up in the very next cycle. It appears either as the wrong port winning a simultaneous request or as the parked ready flag moving while both ports are idle. A mistake in the address, byte-enable or data steering appears only later, when a read returns the word. The random phase therefore uses a narrow address range, so that reads follow writes to the same words within a few cycles. A wrong return-path register shows up one cycle after a read, as data on the wrong port or a non-zero bus on an idle port.

// File: rtl/sram_share_pkg.sv
package sram_share_pkg;

  typedef enum logic {
    PORT_CPU = 1'b0,
    PORT_BUS = 1'b1
  } port_e;

  // Owner for this cycle, from the two requests and the previous owner.
  function automatic port_e pick_owner(input logic cpu_req,
                                       input logic bus_req,
                                       input port_e prev);
    port_e res;
    if (cpu_req && !bus_req)      res = PORT_CPU;
    else if (bus_req && !cpu_req) res = PORT_BUS;
    else if (cpu_req && bus_req)  res = (prev == PORT_CPU) ? PORT_BUS : PORT_CPU;
    else                          res = prev;
    return res;
  endfunction

endpackage

// File: rtl/sram_share_sel.sv
module sram_share_sel
  import sram_share_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cpu_req,
  input  logic  bus_req,
  output port_e owner,
  output logic  cpu_gnt,
  output logic  bus_gnt
);

  port_e last_q;

  always_comb begin
    owner = pick_owner(cpu_req, bus_req, last_q);
  end

  assign cpu_gnt = (owner == PORT_CPU);
  assign bus_gnt = (owner == PORT_BUS);

  // When idle, owner equals last_q, so the grant stays parked.
  always_ff @(posedge clk) begin
    if (rst) last_q <= PORT_CPU;
    else     last_q <= owner;
  end

endmodule

// File: rtl/sram_share_mem.sv
module sram_share_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic                  we,
  input  logic [DATA_W/8-1:0]   be,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);

  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  // One byte-wide array per lane, so each lane maps onto a RAM column.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] lane_rd;

    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[g]) lane_mem[addr] <= wdata[g*8 +: 8];
        if (!we)         lane_rd        <= lane_mem[addr];
      end
    end

    assign rdata[g*8 +: 8] = lane_rd;
  end

endmodule

// File: rtl/sram_share_ret.sv
module sram_share_ret #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_rd_fire,
  input  logic              bus_rd_fire,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] bus_rdata
);

  logic cpu_sel_q;
  logic bus_sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_sel_q <= 1'b0;
      bus_sel_q <= 1'b0;
    end else begin
      cpu_sel_q <= cpu_rd_fire;
      bus_sel_q <= bus_rd_fire;
    end
  end

  assign cpu_rdata = cpu_sel_q ? mem_rdata : '0;
  assign bus_rdata = bus_sel_q ? mem_rdata : '0;

endmodule

// File: rtl/sram_share_arb.sv
module sram_share_arb
  import sram_share_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_we,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_gnt,
  input  logic                bus_req,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_gnt
);

  localparam int BE_W = DATA_W / 8;

  port_e             owner;
  logic              cpu_fire;
  logic              bus_fire;
  logic              m_en;
  logic              m_we;
  logic [BE_W-1:0]   m_be;
  logic [ADDR_W-1:0] m_addr;
  logic [DATA_W-1:0] m_wdata;
  logic [DATA_W-1:0] m_rdata;

  sram_share_sel sel_i (
    .clk     (clk),
    .rst     (rst),
    .cpu_req (cpu_req),
    .bus_req (bus_req),
    .owner   (owner),
    .cpu_gnt (cpu_gnt),
    .bus_gnt (bus_gnt)
  );

  assign cpu_fire = cpu_req && cpu_gnt;
  assign bus_fire = bus_req && bus_gnt;

  always_comb begin
    m_en = cpu_fire || bus_fire;
    if (owner == PORT_BUS) begin
      m_we    = bus_we;
      m_be    = bus_be;
      m_addr  = bus_addr;
      m_wdata = bus_wdata;
    end else begin
      m_we    = cpu_we;
      m_be    = cpu_be;
      m_addr  = cpu_addr;
      m_wdata = cpu_wdata;
    end
  end

  sram_share_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) mem_i (
    .clk   (clk),
    .en    (m_en),
    .we    (m_we),
    .be    (m_be),
    .addr  (m_addr),
    .wdata (m_wdata),
    .rdata (m_rdata)
  );

  sram_share_ret #(
    .DATA_W (DATA_W)
  ) ret_i (
    .clk         (clk),
    .rst         (rst),
    .cpu_rd_fire (cpu_fire && !cpu_we),
    .bus_rd_fire (bus_fire && !bus_we),
    .mem_rdata   (m_rdata),
    .cpu_rdata   (cpu_rdata),
    .bus_rdata   (bus_rdata)
  );

endmodule

// File: rtl/sram_share_chk.sv
module sram_share_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_gnt,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_gnt,
  input logic [DATA_W-1:0] bus_rdata
);

  assert_one_owner_R5: assert property (@(posedge clk) disable iff (rst)
    $countones({cpu_gnt, bus_gnt}) == 1);

  assert_lone_cpu_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !bus_req) |-> cpu_gnt);

  assert_lone_bus_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !cpu_req) |-> bus_gnt);

  assert_cpu_wait_one_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_gnt) |=> (!cpu_req || cpu_gnt));

  assert_bus_wait_one_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (!bus_req || bus_gnt));

  assert_cpu_park_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_gnt |=> (bus_req || cpu_gnt));

  assert_bus_park_R4: assert property (@(posedge clk) disable iff (rst)
    bus_gnt |=> (cpu_req || bus_gnt));

  assert_cpu_rdata_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_req && cpu_gnt && !cpu_we) |-> (cpu_rdata == '0));

  assert_bus_rdata_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_req && bus_gnt && !bus_we) |-> (bus_rdata == '0));

endmodule

bind sram_share_arb sram_share_chk #(
  .DATA_W (DATA_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_gnt   (cpu_gnt),
  .cpu_rdata (cpu_rdata),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_gnt   (bus_gnt),
  .bus_rdata (bus_rdata)
);

// File: tb/sram_share_arb_tb.sv
module sram_share_arb_tb_top;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0, bus_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0, bus_addr = '0;
  logic          cpu_we = 1'b0, bus_we = 1'b0;
  logic [BW-1:0] cpu_be = '0, bus_be = '0;
  logic [DW-1:0] cpu_wdata = '0, bus_wdata = '0;
  logic [DW-1:0] cpu_rdata, bus_rdata;
  logic          cpu_gnt, bus_gnt;

  always #5 clk = ~clk;

  sram_share_arb #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_gnt(cpu_gnt),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_gnt(bus_gnt)
  );

  int          n_run = 0;
  int          n_fail = 0;
  logic [DW-1:0] mem_m [1 << AW];
  bit          last_m = 1'b0;      // 0 = processor port, 1 = bus port
  bit          own_m = 1'b0;       // owner predicted in the latest step
  bit          exp_cv = 1'b0, exp_bv = 1'b0;
  logic [DW-1:0] exp_cd = '0, exp_bd = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_owner(input bit cr, input bit br, input bit prev);
    if (cr && !br) return 1'b0;
    if (br && !cr) return 1'b1;
    if (cr && br)  return !prev;
    return prev;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] wd,
                                          input logic [BW-1:0] be);
    logic [DW-1:0] r = old;
    for (int b = 0; b < BW; b++) if (be[b]) r[b*8 +: 8] = wd[b*8 +: 8];
    return r;
  endfunction

  // Inputs are set at a negedge; this checks grants, advances the model,
  // crosses one rising edge and checks read data at the next negedge.
  task automatic step();
    string tag;
    #1;
    own_m = exp_owner(cpu_req, bus_req, last_m);
    if (cpu_req && bus_req)       tag = "R3 contention grant";
    else if (cpu_req || bus_req)  tag = "R2 lone grant";
    else                          tag = "R4 parked grant";
    chk(tag, {31'd0, cpu_gnt}, {31'd0, !own_m});
    chk(tag, {31'd0, bus_gnt}, {31'd0, own_m});
    chk("R5 one owner", {30'd0, cpu_gnt, bus_gnt}, own_m ? 32'd1 : 32'd2);
    exp_cv = 1'b0;
    exp_bv = 1'b0;
    if (!own_m && cpu_req) begin
      if (cpu_we) mem_m[cpu_addr] = merge(mem_m[cpu_addr], cpu_wdata, cpu_be);
      else begin exp_cv = 1'b1; exp_cd = mem_m[cpu_addr]; end
    end
    if (own_m && bus_req) begin
      if (bus_we) mem_m[bus_addr] = merge(mem_m[bus_addr], bus_wdata, bus_be);
      else begin exp_bv = 1'b1; exp_bd = mem_m[bus_addr]; end
    end
    last_m = own_m;
    @(posedge clk);
    @(negedge clk);
    chk("R7 cpu read return", cpu_rdata, exp_cv ? exp_cd : '0);
    chk("R7 bus read return", bus_rdata, exp_bv ? exp_bd : '0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    bit cpu_hold, bus_hold;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset cpu_gnt", {31'd0, cpu_gnt}, 32'd1);
    chk("R1 reset bus_gnt", {31'd0, bus_gnt}, 32'd0);
    chk("R1 reset cpu_rdata", cpu_rdata, '0);
    chk("R1 reset bus_rdata", bus_rdata, '0);
    @(negedge clk);

    // Fill the whole SRAM from the bus port alone (R2).
    for (int i = 0; i < (1 << AW); i++) begin
      bus_req = 1'b1; bus_we = 1'b1; bus_be = '1;
      bus_addr = AW'(i); bus_wdata = (32'h01010101 * i) ^ 32'hA5A50000;
      step();
    end
    bus_req = 1'b0; bus_we = 1'b0;
    step();                       // R4: grant stays on the bus port
    step();

    // R6: partial-word store.
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_be = 4'hF; cpu_addr = 8'd5; cpu_wdata = 32'h11223344;
    step();
    cpu_be = 4'b0101; cpu_wdata = 32'hAABBCCDD;
    step();
    cpu_we = 1'b0;
    #1;
    own_m = 1'b0;
    step();
    chk("R6 byte enables", cpu_rdata, 32'h11BB33DD);

    // R8: write fields with request low, while parked on this port.
    cpu_req = 1'b0; cpu_we = 1'b1; cpu_be = 4'hF; cpu_wdata = 32'hFFFFFFFF;
    step();
    step();
    cpu_req = 1'b1; cpu_we = 1'b0;
    step();
    chk("R8 idle write ignored", cpu_rdata, 32'h11BB33DD);
    cpu_req = 1'b0;
    step();

    // R3: back-to-back contention, reads on both ports.
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'd1;
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'd2;
    for (int k = 0; k < 8; k++) begin
      step();
      if (own_m) bus_addr = bus_addr + 8'd1;
      else       cpu_addr = cpu_addr + 8'd1;
    end
    cpu_req = 1'b0; bus_req = 1'b0;
    step();

    // Random mix over a narrow address range.
    cpu_hold = 1'b0;
    bus_hold = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (!cpu_hold) begin
        cpu_req = ($urandom % 10) < 6;
        cpu_we = $urandom % 2;
        cpu_be = BW'($urandom);
        cpu_addr = AW'($urandom % 16);
        cpu_wdata = $urandom;
      end
      if (!bus_hold) begin
        bus_req = ($urandom % 10) < 6;
        bus_we = $urandom % 2;
        bus_be = BW'($urandom);
        bus_addr = AW'($urandom % 16);
        bus_wdata = $urandom;
      end
      step();
      cpu_hold = cpu_req && own_m;
      bus_hold = bus_req && !own_m;
    end

    cpu_req = 1'b0;
    bus_req = 1'b0;
    step();
    summary();
    $finish;
  end

endmodule